// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block lets a core reach external memory and IO devices through one 8-bit port that carries address bytes and data bytes at different times. The core gives a single request: a 16-bit address, a write byte, a read/write flag, a memory/IO flag and, for IO, a command/data flag. The block then plays the strobe sequence on the bus pins. It answers with a one-cycle done pulse, and with the captured byte when the request was a read.

A memory transfer puts the upper address byte on the port while pulsing the high-latch strobe. It then puts the lower address byte on the port while pulsing the low-latch strobe. Last comes one data cycle, with the active-low read or write strobe. The block remembers which upper byte the external high latch holds. A transfer in the same 256-byte page therefore skips the high-latch cycle.

An IO transfer has no address cycles. It goes straight to the data cycle and raises either the command strobe or the data strobe next to the read or write strobe. The port direction pin is 1 (port released) when idle and in read data cycles, and 0 whenever the block drives an address byte or a write byte.

Top module: `adbus_master`

## Requirements
- R1: After reset the bus is idle: `bus_dir`=1, `rd_n`=1, `wr_n`=1, `lat_hi`, `lat_lo`, `io_cmd`, `io_dat` all 0, `req_ready`=1 and `rsp_valid`=0.
- R2: A memory transfer whose upper address byte needs latching runs three cycles after acceptance:
  - the first has `lat_hi`=1 with addr[15:8] on `bus_out`;
  - the second has `lat_lo`=1 with addr[7:0] on `bus_out`;
  - the third is the data cycle.
  `bus_dir`=0 in both address cycles.
- R3: A memory transfer whose upper byte equals the byte last latched skips the `lat_hi` cycle. Its first cycle after acceptance is the `lat_lo` cycle.
- R4: The first memory transfer after reset always issues `lat_hi`, whatever its upper address byte, including 0x00.
- R5: In the data cycle of a read, `rd_n`=0 for exactly one cycle and `bus_dir`=1. `bus_in` is sampled at the clock edge that ends that cycle. In the next cycle `rsp_valid`=1 for one cycle, with that byte on `rsp_rdata`.
- R6: In the data cycle of a write, `wr_n`=0 for exactly one cycle, with the write byte on `bus_out`. `bus_dir` stays 0 from the first address cycle through the data cycle. `rsp_valid`=1 for one cycle after it.
- R7: An IO transfer has no address cycle. Its first cycle after acceptance is the data cycle, with `io_cmd`=1 if `req_cmd`=1, otherwise `io_dat`=1, together with `rd_n`=0 (read) or `wr_n`=0 (write).
- R8: An IO transfer leaves the tracked upper byte unchanged. A later memory transfer to the page last latched still skips `lat_hi`.
- R9: `req_ready`=0 from acceptance until the done cycle. A `req_valid` raised while `req_ready`=0 is ignored: the running transfer's bytes stay on the bus and no extra transfer starts.
- R10: Of `lat_hi`, `lat_lo`, active `rd_n` and active `wr_n`, at most one is asserted in any cycle.
- R11: `req_ready`=1 in the done cycle. A request presented then is accepted at once, so a new transfer begins right after the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = IO transfer, 0 = memory transfer |
| req_cmd | input | 1 | For IO: 1 = command byte, 0 = data byte |
| req_addr | input | 16 | Memory address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_rdata | output | 8 | Byte captured in the last read |
| bus_out | output | 8 | Value driven onto the shared port |
| bus_in | input | 8 | Value read from the shared port |
| bus_dir | output | 1 | 1 = port released, 0 = port driven |
| lat_hi | output | 1 | High address latch strobe, active high |
| lat_lo | output | 1 | Low address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_cmd | output | 1 | IO command strobe, active high |
| io_dat | output | 1 | IO data strobe, active high |

## Verification
The done pulse of one transfer and the acceptance of the next request fall in the same cycle. In that cycle the page tracker's state, written by the earlier transfer, decides whether the new transfer needs a high-latch cycle. The bench provokes this by presenting a same-page read while the done pulse of the previous read is still showing. It then checks that the pulse carries the old byte, and that the very next cycle is a low-latch cycle driving the new low address byte. A busy-time request with a different address is also held on the inputs. The bus bytes and the later page-hit behaviour show whether it leaked into the sequence or the tracker.

// File: rtl/adbus_pkg.sv
package adbus_pkg;
  localparam int unsigned BUS_W_DEF  = 8;
  localparam int unsigned ADDR_W_DEF = 16;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HI   = 2'd1,
    PH_LO   = 2'd2,
    PH_DATA = 2'd3
  } phase_e;
endpackage

// File: rtl/adbus_page_track.sv
module adbus_page_track #(
  parameter int unsigned PG_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PG_W-1:0] load_page,
  input  logic [PG_W-1:0] probe_page,
  output logic            miss,
  output logic [PG_W-1:0] held_page,
  output logic            held_valid
);
  logic            valid_q;
  logic [PG_W-1:0] page_q;

  function automatic logic page_miss(input logic v, input logic [PG_W-1:0] held,
                                     input logic [PG_W-1:0] want);
    return !v || (held != want);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      page_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      page_q  <= load_page;
    end
  end

  assign miss       = page_miss(valid_q, page_q, probe_page);
  assign held_page  = page_q;
  assign held_valid = valid_q;

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    held_valid |=> held_valid); // R4
endmodule

// File: rtl/adbus_seq.sv
module adbus_seq
  import adbus_pkg::*;
#(
  parameter int unsigned BUS_W  = BUS_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_io,
  input  logic              req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic              page_miss,
  input  logic [BUS_W-1:0]  bus_in,
  output phase_e            phase,
  output logic              x_write,
  output logic              x_io,
  output logic              x_cmd,
  output logic [ADDR_W-1:0] x_addr,
  output logic [BUS_W-1:0]  x_wdata,
  output logic              hi_load,
  output logic              accept,
  output logic              rsp_valid,
  output logic [BUS_W-1:0]  rsp_rdata
);
  phase_e            ph_q, ph_d;
  logic              write_q, io_q, cmd_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BUS_W-1:0]  wdata_q, rdata_q;

  function automatic phase_e first_phase(input logic io, input logic miss);
    if (io)        return PH_DATA;
    else if (miss) return PH_HI;
    else           return PH_LO;
  endfunction

  assign accept = (ph_q == PH_IDLE) && req_valid;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (req_valid) ph_d = first_phase(req_io, page_miss);
      PH_HI:   ph_d = PH_LO;
      PH_LO:   ph_d = PH_DATA;
      PH_DATA: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      write_q <= 1'b0;
      io_q    <= 1'b0;
      cmd_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= (ph_q == PH_DATA);
      if (accept) begin
        write_q <= req_write;
        io_q    <= req_io;
        cmd_q   <= req_cmd;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if ((ph_q == PH_DATA) && !write_q) rdata_q <= bus_in;
    end
  end

  assign phase     = ph_q;
  assign req_ready = (ph_q == PH_IDLE);
  assign x_write   = write_q;
  assign x_io      = io_q;
  assign x_cmd     = cmd_q;
  assign x_addr    = addr_q;
  assign x_wdata   = wdata_q;
  assign hi_load   = (ph_q == PH_HI);
  assign rsp_valid = done_q;
  assign rsp_rdata = rdata_q;

  AST_HI_THEN_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HI) |=> (phase == PH_LO)); // R2
  AST_LO_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LO) |=> (phase == PH_DATA)); // R2
  AST_DONE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA) |=> (rsp_valid && req_ready)); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid || $past(accept && req_io)); // R5
  AST_BUSY_HOLDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && (phase != PH_DATA)) |=> $stable(x_addr) && $stable(x_write)); // R9
  AST_IO_SKIPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_io) |=> (phase == PH_DATA)); // R7
endmodule

// File: rtl/adbus_drive.sv
module adbus_drive
  import adbus_pkg::*;
#(
  parameter int unsigned BUS_W  = BUS_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  phase_e            phase,
  input  logic              x_write,
  input  logic              x_io,
  input  logic              x_cmd,
  input  logic [ADDR_W-1:0] x_addr,
  input  logic [BUS_W-1:0]  x_wdata,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_dir,
  output logic              lat_hi,
  output logic              lat_lo,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_cmd,
  output logic              io_dat
);
  localparam int unsigned HI_W = ADDR_W - BUS_W;

  logic [BUS_W-1:0] hi_byte, lo_byte;
  logic             in_data;

  assign lo_byte = x_addr[BUS_W-1:0];

  generate
    if (HI_W >= BUS_W) begin : g_hi_full
      assign hi_byte = x_addr[ADDR_W-1 -: BUS_W];
    end else begin : g_hi_pad
      assign hi_byte = {{(BUS_W-HI_W){1'b0}}, x_addr[ADDR_W-1:BUS_W]};
    end
  endgenerate

  assign in_data = (phase == PH_DATA);

  always_comb begin
    unique case (phase)
      PH_HI:   bus_out = hi_byte;
      PH_LO:   bus_out = lo_byte;
      PH_DATA: bus_out = x_write ? x_wdata : '0;
      default: bus_out = '0;
    endcase
  end

  assign bus_dir = !((phase == PH_HI) || (phase == PH_LO) || (in_data && x_write));
  assign lat_hi  = (phase == PH_HI);
  assign lat_lo  = (phase == PH_LO);
  assign rd_n    = !(in_data && !x_write);
  assign wr_n    = !(in_data && x_write);
  assign io_cmd  = in_data && x_io && x_cmd;
  assign io_dat  = in_data && x_io && !x_cmd;

  always_comb begin
    AST_STROBE_EXCLUSIVE: assert ($onehot0({lat_hi, lat_lo, !rd_n, !wr_n})); // R10
    AST_IO_NEEDS_RW: assert (!(io_cmd || io_dat) || (rd_n != wr_n)); // R7
  end
endmodule

// File: rtl/adbus_master.sv
module adbus_master
  import adbus_pkg::*;
#(
  parameter int unsigned BUS_W  = BUS_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_io,
  input  logic              req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [BUS_W-1:0]  rsp_rdata,
  output logic [BUS_W-1:0]  bus_out,
  input  logic [BUS_W-1:0]  bus_in,
  output logic              bus_dir,
  output logic              lat_hi,
  output logic              lat_lo,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_cmd,
  output logic              io_dat
);
  localparam int unsigned PG_W = ADDR_W - BUS_W;

  phase_e            phase;
  logic              x_write, x_io, x_cmd, hi_load, accept, trk_miss, trk_valid;
  logic [ADDR_W-1:0] x_addr;
  logic [BUS_W-1:0]  x_wdata;
  logic [PG_W-1:0]   trk_page;

  adbus_page_track #(.PG_W(PG_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (hi_load),
    .load_page  (x_addr[ADDR_W-1:BUS_W]),
    .probe_page (req_addr[ADDR_W-1:BUS_W]),
    .miss       (trk_miss),
    .held_page  (trk_page),
    .held_valid (trk_valid)
  );

  adbus_seq #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_io    (req_io),
    .req_cmd   (req_cmd),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .page_miss (trk_miss),
    .bus_in    (bus_in),
    .phase     (phase),
    .x_write   (x_write),
    .x_io      (x_io),
    .x_cmd     (x_cmd),
    .x_addr    (x_addr),
    .x_wdata   (x_wdata),
    .hi_load   (hi_load),
    .accept    (accept),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  adbus_drive #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_drive (
    .phase   (phase),
    .x_write (x_write),
    .x_io    (x_io),
    .x_cmd   (x_cmd),
    .x_addr  (x_addr),
    .x_wdata (x_wdata),
    .bus_out (bus_out),
    .bus_dir (bus_dir),
    .lat_hi  (lat_hi),
    .lat_lo  (lat_lo),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .io_cmd  (io_cmd),
    .io_dat  (io_dat)
  );

  AST_IO_KEEPS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_cmd || io_dat) |=> $stable(trk_page) && $stable(trk_valid)); // R8
  AST_FIRST_MEM_LATCHES_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_io && !trk_valid) |=> lat_hi); // R4
  AST_WRITE_KEEPS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_lo && x_write) |=> !bus_dir && !wr_n); // R6
  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> bus_dir); // R5
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_hi || lat_lo || !rd_n || !wr_n) |-> !req_ready); // R9
endmodule

// File: tb/adbus_master_bench.sv
module adbus_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0, req_cmd = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, bus_in = '0;
  logic        req_ready, rsp_valid, bus_dir, lat_hi, lat_lo, rd_n, wr_n, io_cmd, io_dat;
  logic [7:0]  rsp_rdata, bus_out;
  int          total = 0, bad = 0;

  always #2.5 clk = ~clk;

  adbus_master u_adbus_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_io(req_io), .req_cmd(req_cmd), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_out(bus_out), .bus_in(bus_in), .bus_dir(bus_dir), .lat_hi(lat_hi),
    .lat_lo(lat_lo), .rd_n(rd_n), .wr_n(wr_n), .io_cmd(io_cmd), .io_dat(io_dat)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic idle_state(input string tag);
    check(bus_dir && rd_n && wr_n && !lat_hi && !lat_lo && !io_cmd && !io_dat && req_ready,
          {tag, " idle pins"},
          {bus_dir, rd_n, wr_n, lat_hi, lat_lo, io_cmd, io_dat, req_ready}, 8'b1110_0001);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Starts at a negedge, ends at the negedge of the done cycle.
  task automatic run_xfer(input bit wr, input bit io, input bit cmd, input logic [15:0] addr,
                          input logic [7:0] wd, input logic [7:0] rv, input bit exp_hi,
                          input bit noise, input string tag);
    req_valid = 1'b1; req_write = wr; req_io = io; req_cmd = cmd;
    req_addr = addr;  req_wdata = wd;
    @(negedge clk);
    if (noise) begin
      req_addr = addr ^ 16'hA5A5; req_wdata = ~wd; req_write = !wr;
    end else req_valid = 1'b0;
    if (!io && exp_hi) begin
      check(lat_hi && !lat_lo && bus_out == addr[15:8] && !bus_dir && !req_ready,
            {tag, " R2 R4 hi cycle"}, {lat_hi, lat_lo, bus_dir, bus_out}, {3'b100, addr[15:8]});
      @(negedge clk);
    end
    if (!io) begin
      check(lat_lo && !lat_hi && bus_out == addr[7:0] && !bus_dir && !req_ready,
            {tag, " R2 R3 lo cycle"}, {lat_hi, lat_lo, bus_dir, bus_out}, {3'b010, addr[7:0]});
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(!lat_hi && !lat_lo && rd_n == wr && wr_n == !wr && !req_ready,
          {tag, " R5 R6 R10 data strobes"}, {lat_hi, lat_lo, rd_n, wr_n}, {2'b00, wr, !wr});
    check(io_cmd == (io && cmd) && io_dat == (io && !cmd), {tag, " R7 io strobes"},
          {io_cmd, io_dat}, {io && cmd, io && !cmd});
    if (wr) check(!bus_dir && bus_out == wd, {tag, " R6 write byte driven"},
                  {bus_dir, bus_out}, {1'b0, wd});
    else begin
      check(bus_dir, {tag, " R5 port released"}, bus_dir, 1);
      bus_in = rv;
    end
    check(!rsp_valid, {tag, " R5 no early done"}, rsp_valid, 0);
    @(negedge clk);
    bus_in = 8'h00;
    check(rsp_valid, {tag, " R5 R6 done pulse"}, rsp_valid, 1);
    if (!wr) check(rsp_rdata == rv, {tag, " R5 read byte"}, rsp_rdata, rv);
    idle_state({tag, " R11 done cycle"});
  endtask

  task automatic after_done(input string tag);
    @(negedge clk);
    check(!rsp_valid, {tag, " R5 single pulse"}, rsp_valid, 0);
    idle_state(tag);
  endtask

  task automatic t_reset();
    do_reset();
    idle_state("R1 reset");
    check(!rsp_valid, "R1 no done after reset", rsp_valid, 0);
  endtask

  task automatic t_first_and_page();
    run_xfer(1'b0, 1'b0, 1'b0, 16'h1234, 8'h00, 8'h9C, 1'b1, 1'b0, "R4 first read");
    after_done("R4 first read");
    run_xfer(1'b1, 1'b0, 1'b0, 16'h1280, 8'h3E, 8'h00, 1'b0, 1'b0, "R3 same page write");
    after_done("R3 same page write");
    run_xfer(1'b0, 1'b0, 1'b0, 16'h5600, 8'h00, 8'h41, 1'b1, 1'b0, "R2 new page read");
    after_done("R2 new page read");
  endtask

  task automatic t_io();
    run_xfer(1'b1, 1'b1, 1'b1, 16'h0000, 8'hC7, 8'h00, 1'b0, 1'b0, "R7 io cmd write");
    after_done("R7 io cmd write");
    run_xfer(1'b0, 1'b1, 1'b0, 16'hFFFF, 8'h00, 8'h5A, 1'b0, 1'b0, "R7 io data read");
    after_done("R7 io data read");
    run_xfer(1'b0, 1'b0, 1'b0, 16'h5610, 8'h00, 8'h77, 1'b0, 1'b0, "R8 page kept over io");
  endtask

  task automatic t_back_to_back();
    run_xfer(1'b0, 1'b0, 1'b0, 16'h5620, 8'h00, 8'hE1, 1'b0, 1'b0, "R11 chained read");
    run_xfer(1'b1, 1'b0, 1'b0, 16'h5621, 8'h0F, 8'h00, 1'b0, 1'b0, "R11 chained write");
    after_done("R11 chained write");
  endtask

  task automatic t_busy_ignored();
    run_xfer(1'b1, 1'b0, 1'b0, 16'h7701, 8'hB4, 8'h00, 1'b1, 1'b1, "R9 busy request");
    after_done("R9 busy request");
    run_xfer(1'b0, 1'b0, 1'b0, 16'h7702, 8'h00, 8'h18, 1'b0, 1'b0, "R9 tracker untouched");
    after_done("R9 tracker untouched");
  endtask

  task automatic t_zero_page_after_reset();
    do_reset();
    run_xfer(1'b0, 1'b0, 1'b0, 16'h0005, 8'h00, 8'h66, 1'b1, 1'b0, "R4 zero page");
    after_done("R4 zero page");
    run_xfer(1'b0, 1'b0, 1'b0, 16'h00F0, 8'h00, 8'h99, 1'b0, 1'b0, "R3 zero page hit");
    after_done("R3 zero page hit");
  endtask

  initial begin
    t_reset();
    t_first_and_page();
    t_io();
    t_back_to_back();
    t_busy_ignored();
    t_zero_page_after_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule